// File: doc/BRIEF.md
# Serial Frame Transmit Controller

This block sequences one outgoing frame on a serial link and keeps the status that software polls to learn how the frame ended. Software writes the transmit enable and then feeds up to three bytes into a small queue. While the enable is high and the queue holds data, the controller runs the frame through these phases: preamble, data bytes, checksum, closing flag, and an optional interframe wait for an acknowledge. Each data byte is handed to an external shifter with a one-cycle load pulse. All phases advance on a bit-time tick supplied from outside. The bit shifter, checksum generator and receiver are not part of the block. They appear only as handshake and event inputs.

The frame can end in one of five ways, and each way leaves its own footprint in the status byte. A clean finish sets done. A collision during data or checksum sets the collision flag, and so do too many collisions in the preamble. In DMA mode, running out of queued bytes while the DMA count is nonzero sets underrun. A missing acknowledge sets no-ack. Software clearing the enable mid-frame aborts the frame. Every hardware ending except an abort also drops the enable.

Top module: `frame_tx_ctrl`

## Requirements
- R1: A register write with data bit 0 = 1 sets the enable (status bit 0), clears done (bit 2), collision (bit 3), underrun (bit 4) and no-ack (bit 5), empties the queue and resets the collision count; bytes written before it are never sent.
- R2: The queue holds three bytes and sends them in write order; status bit 1 (not-full) is 1 while fewer than three bytes are held, and a byte written while the queue is full is dropped.
- R3: Bits 7..1 of a register write have no effect; status flags change only by hardware, and a write with bit 0 = 0 only clears the enable.
- R4: With the enable set and the queue non-empty, the frame runs 8 bit times of preamble, 8 per data byte, CRC_BITS of checksum and 8 of closing flag; without acknowledge checking, done and enable-clear happen on the last tick of the closing flag.
- R5: With acknowledge checking on, the result is postponed by IFS_BITS bit times after the closing flag; done is set if ack_in was seen during that wait, otherwise no-ack is set and done stays 0. An acknowledge before the wait is ignored.
- R6: For a broadcast or multicast frame (bcast = 1), no-ack is never set; the frame ends with done.
- R7: A collision during data or checksum sets the collision flag, clears the enable and stops the frame; a collision during the closing flag stops the frame and clears the enable without setting any flag.
- R8: Each collision in the preamble restarts it; the ninth collision since the last enable write sets the collision flag and clears the enable, while eight still let the frame finish.
- R9: In DMA mode with dma_zero = 0, sending the last queued byte sets underrun, clears the enable and skips checksum and closing flag; with dma_zero = 1 the frame finishes normally.
- R10: Clearing the enable mid-frame forces tx_hold_hi high from the next cycle, stops further byte loads and sets no flag; tx_hold_hi is high whenever the enable is low.
- R11: At most one of done, collision, underrun and no-ack is set at any time, and a load pulse occurs only while the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data; only bit 0 (enable) is used |
| reg_rdata | output | 8 | Status: 0 enable, 1 not-full, 2 done, 3 collision, 4 underrun, 5 no-ack |
| fifo_wr | input | 1 | Queue write strobe |
| fifo_wdata | input | 8 | Byte to queue |
| bit_tick | input | 1 | One pulse per bit time |
| coll_in | input | 1 | Collision event from the line logic |
| ack_in | input | 1 | Acknowledge detected by the line logic |
| ack_en | input | 1 | Acknowledge checking enabled |
| bcast | input | 1 | Current frame is broadcast or multicast |
| dma_mode | input | 1 | Bytes are supplied by DMA |
| dma_zero | input | 1 | DMA byte count has reached zero |
| shift_load | output | 1 | One-cycle pulse: shift_byte is valid for the shifter |
| shift_byte | output | 8 | Byte handed to the shifter |
| tx_hold_hi | output | 1 | Line held at steady high (idle or aborted) |

## Verification
The bound checker watches on every cycle that an enable write clears the flags and empties the queue, and that a write of 0 holds the line high. It also checks that the line is high whenever the enable is low, that the four end flags never overlap, and that loads happen only while enabled. The bench alone can show the cycle counts of the frame phases, the postponement of done by the interframe wait, and the dropping of an early acknowledge. It also covers the collision limit at exactly eight and nine, the per-phase collision outcomes, underrun, and the abort. A random mix of frame sizes, tick gaps, collision counts and acknowledge settings is checked against an outcome function.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  localparam int QDEPTH   = 3;
  localparam int MAX_COLL = 8;
  localparam int FLAG_LEN = 8;

  localparam int ST_EN    = 0;
  localparam int ST_NF    = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_COLL  = 3;
  localparam int ST_UNDER = 4;
  localparam int ST_NOACK = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_DATA, PH_CRC, PH_EFLAG, PH_IFS
  } phase_t;
endpackage

// File: rtl/ftx_fifo.sv
module ftx_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         not_full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty    = (cnt == '0);
  assign not_full = (cnt != CW'(DEPTH));
  assign do_push  = push && not_full && !flush;
  assign do_pop   = pop && !empty && !flush;
  assign dout     = mem[rptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ftx_seq.sv
module ftx_seq
  import frame_tx_pkg::*;
#(
  parameter int CRC_BITS = 16,
  parameter int IFS_BITS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic bit_tick,
  input  logic coll_in,
  input  logic ack_in,
  input  logic ack_en,
  input  logic bcast,
  input  logic dma_mode,
  input  logic dma_zero,
  input  logic fifo_empty,
  output logic pop,
  output logic ev_done,
  output logic ev_coll,
  output logic ev_under,
  output logic ev_noack,
  output logic ev_stop,
  output logic idle
);
  localparam int ML  = (CRC_BITS > IFS_BITS) ? CRC_BITS : IFS_BITS;
  localparam int MX  = (ML > FLAG_LEN) ? ML : FLAG_LEN;
  localparam int BW  = $clog2(MX + 1);
  localparam int CCW = $clog2(MAX_COLL + 2);

  phase_t         state, nstate;
  logic [BW-1:0]  bcnt, nbcnt, len;
  logic [CCW-1:0] ccnt, nccnt;
  logic           acked, nacked, last;

  assign idle = (state == PH_IDLE);

  always_comb begin
    case (state)
      PH_CRC:  len = BW'(CRC_BITS);
      PH_IFS:  len = BW'(IFS_BITS);
      default: len = BW'(FLAG_LEN);
    endcase
    last = bit_tick && (bcnt == len - 1'b1);
  end

  always_comb begin
    nstate = state; nbcnt = bcnt; nccnt = ccnt; nacked = acked;
    pop = 1'b0; ev_done = 1'b0; ev_coll = 1'b0;
    ev_under = 1'b0; ev_noack = 1'b0; ev_stop = 1'b0;
    if (bit_tick && !last) nbcnt = bcnt + 1'b1;
    if (!clr) begin
      case (state)
        PH_IDLE: begin
          nbcnt = '0;
          if (en && !fifo_empty) nstate = PH_PRE;
        end
        PH_PRE: begin
          if (coll_in) begin
            nbcnt = '0;
            nccnt = ccnt + 1'b1;
            if (ccnt == CCW'(MAX_COLL)) begin
              ev_coll = 1'b1; ev_stop = 1'b1; nstate = PH_IDLE;
            end
          end else if (last) begin
            pop = 1'b1; nbcnt = '0; nstate = PH_DATA;
          end
        end
        PH_DATA: begin
          if (coll_in) begin
            ev_coll = 1'b1; ev_stop = 1'b1; nstate = PH_IDLE;
          end else if (last) begin
            nbcnt = '0;
            if (!fifo_empty) pop = 1'b1;
            else if (dma_mode && !dma_zero) begin
              ev_under = 1'b1; ev_stop = 1'b1; nstate = PH_IDLE;
            end else nstate = PH_CRC;
          end
        end
        PH_CRC: begin
          if (coll_in) begin
            ev_coll = 1'b1; ev_stop = 1'b1; nstate = PH_IDLE;
          end else if (last) begin
            nbcnt = '0; nstate = PH_EFLAG;
          end
        end
        PH_EFLAG: begin
          if (coll_in) begin
            ev_stop = 1'b1; nstate = PH_IDLE;
          end else if (last) begin
            nbcnt = '0; nacked = 1'b0;
            if (ack_en) nstate = PH_IFS;
            else begin
              ev_done = 1'b1; ev_stop = 1'b1; nstate = PH_IDLE;
            end
          end
        end
        PH_IFS: begin
          if (ack_in) nacked = 1'b1;
          if (last) begin
            ev_stop = 1'b1; nstate = PH_IDLE;
            if (bcast || acked || ack_in) ev_done = 1'b1;
            else ev_noack = 1'b1;
          end
        end
        default: nstate = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state <= PH_IDLE;
      bcnt  <= '0;
      ccnt  <= '0;
      acked <= 1'b0;
    end else begin
      state <= nstate;
      bcnt  <= nbcnt;
      ccnt  <= nccnt;
      acked <= nacked;
    end
  end
endmodule

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int CRC_BITS = 16,
  parameter int IFS_BITS = 12,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          fifo_wr,
  input  logic [DW-1:0] fifo_wdata,
  input  logic          bit_tick,
  input  logic          coll_in,
  input  logic          ack_in,
  input  logic          ack_en,
  input  logic          bcast,
  input  logic          dma_mode,
  input  logic          dma_zero,
  output logic          shift_load,
  output logic [DW-1:0] shift_byte,
  output logic          tx_hold_hi
);
  logic          en_q, done_q, coll_q, under_q, noack_q;
  logic          wr_on, q_empty, q_nf, pop;
  logic          ev_done, ev_coll, ev_under, ev_noack, ev_stop, idle;
  logic [DW-1:0] q_dout;
  logic          unused_wbits;

  assign unused_wbits = &{1'b0, reg_wdata[7:1]};
  assign wr_on        = reg_wr && reg_wdata[0];

  ftx_fifo #(.DEPTH(QDEPTH), .W(DW)) u_fifo (
    .clk(clk), .rst(rst), .flush(wr_on), .push(fifo_wr), .din(fifo_wdata),
    .pop(pop), .dout(q_dout), .empty(q_empty), .not_full(q_nf)
  );

  ftx_seq #(.CRC_BITS(CRC_BITS), .IFS_BITS(IFS_BITS)) u_seq (
    .clk(clk), .rst(rst), .clr(reg_wr), .en(en_q), .bit_tick(bit_tick),
    .coll_in(coll_in), .ack_in(ack_in), .ack_en(ack_en), .bcast(bcast),
    .dma_mode(dma_mode), .dma_zero(dma_zero), .fifo_empty(q_empty),
    .pop(pop), .ev_done(ev_done), .ev_coll(ev_coll), .ev_under(ev_under),
    .ev_noack(ev_noack), .ev_stop(ev_stop), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; done_q <= 1'b0; coll_q <= 1'b0;
      under_q <= 1'b0; noack_q <= 1'b0;
    end else begin
      if (reg_wr)       en_q <= reg_wdata[0];
      else if (ev_stop) en_q <= 1'b0;
      if (wr_on) begin
        done_q <= 1'b0; coll_q <= 1'b0; under_q <= 1'b0; noack_q <= 1'b0;
      end else begin
        if (ev_done)  done_q  <= 1'b1;
        if (ev_coll)  coll_q  <= 1'b1;
        if (ev_under) under_q <= 1'b1;
        if (ev_noack) noack_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_load <= 1'b0;
      shift_byte <= '0;
    end else begin
      shift_load <= pop;
      if (pop) shift_byte <= q_dout;
    end
  end

  assign tx_hold_hi = idle;

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[ST_EN]    = en_q;
    reg_rdata[ST_NF]    = q_nf;
    reg_rdata[ST_DONE]  = done_q;
    reg_rdata[ST_COLL]  = coll_q;
    reg_rdata[ST_UNDER] = under_q;
    reg_rdata[ST_NOACK] = noack_q;
  end
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       shift_load,
  input logic       tx_hold_hi
);
  // R1
  enable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[0]) |=> (reg_rdata[5:0] == 6'b000011));

  // R10
  abort_high_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_wdata[0]) |=> (tx_hold_hi && !reg_rdata[0]));

  // R10
  off_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[0] |-> tx_hold_hi);

  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(reg_rdata[5:2]) <= 1);

  // R11
  load_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    shift_load |-> reg_rdata[0]);

  // R4
  done_drops_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[2]) |-> !reg_rdata[0]);
endmodule

bind frame_tx_ctrl frame_tx_chk u_chk (.*);

// File: tb/sim_frame_tx_ctrl.sv
module sim_frame_tx_ctrl;
  localparam int PER = 10;
  localparam int IFS = 12;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, fifo_wr = 0, coll_in = 0, ack_in = 0;
  logic ack_en = 0, bcast = 0, dma_mode = 0, dma_zero = 0, bit_tick = 1;
  logic [7:0] reg_wdata = 0, fifo_wdata = 0, reg_rdata, shift_byte;
  logic shift_load, tx_hold_hi;
  logic tick_rand = 0;
  int checks = 0, fails = 0, lat = 0, loads = 0;
  logic [7:0] ldq [0:7];

  always #(PER/2) clk = ~clk;

  frame_tx_ctrl #(.CRC_BITS(16), .IFS_BITS(IFS)) u0 (.*);

  always @(posedge clk) if (shift_load) begin
    if (loads < 8) ldq[loads] <= shift_byte;
    loads <= loads + 1;
  end

  always @(negedge clk) bit_tick <= tick_rand ? 1'($urandom % 2) : 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic start_frame(input int n, input logic [7:0] base);
    @(negedge clk); reg_wr = 1; reg_wdata = 8'h01;
    @(negedge clk); reg_wr = 0;
    for (int i = 0; i < n; i++) begin
      fifo_wr = 1; fifo_wdata = base + 8'(i);
      @(negedge clk);
    end
    fifo_wr = 0;
    lat = 1 + n;
  endtask

  task automatic step_to(input int j);
    while (lat < j) begin @(negedge clk); lat++; end
  endtask

  task automatic pulse_coll(input int j);
    step_to(j); coll_in = 1; step_to(j + 1); coll_in = 0;
  endtask

  task automatic wait_end(input string req);
    int t = 0;
    while (reg_rdata[0] && t < 4000) begin @(negedge clk); t++; end
    chk(req, int'(reg_rdata[0]), 0);
  endtask

  // status: bit0 en, bit1 not-full, bit2 done, bit3 coll, bit4 under, bit5 noack
  function automatic logic [5:0] outcome(input int n, input int k, input logic ae,
      input logic bc, input logic ag, input logic dm, input logic dz);
    if (k > 8)           return {4'b0010, n < 3, 1'b0};
    if (dm && !dz)       return 6'b010010;
    if (ae && !bc && !ag) return 6'b100010;
    return 6'b000110;
  endfunction

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 R2 reset state
    chk("R2 reset", int'(reg_rdata), 8'h02);

    // R2 full queue while disabled
    for (int i = 0; i < 3; i++) begin
      fifo_wr = 1; fifo_wdata = 8'h30 + 8'(i); @(negedge clk);
    end
    fifo_wr = 0; @(negedge clk);
    chk("R2 full", int'(reg_rdata[1]), 0);
    // R1 enable flushes queued bytes
    wreg(8'h01);
    chk("R1 flush nf", int'(reg_rdata[1]), 1);
    repeat (40) @(negedge clk);
    chk("R1 no send", loads, 0);

    // R2 order and drop of a fourth byte
    start_frame(3, 8'hA0);
    fifo_wr = 1; fifo_wdata = 8'hEE; @(negedge clk); fifo_wr = 0;
    wait_end("R2 end");
    chk("R2 count", loads, 3);
    chk("R2 b0", int'(ldq[0]), 8'hA0);
    chk("R2 b2", int'(ldq[2]), 8'hA2);
    chk("R4 done", int'(reg_rdata[5:0]), 6'b000110);

    // R3 upper write bits ignored, flags untouched
    wreg(8'hFE);
    chk("R3 ro", int'(reg_rdata[5:0]), 6'b000110);

    // R4 timing without acknowledge
    start_frame(1, 8'h11);
    step_to(42); chk("R4 before", int'(reg_rdata[2]), 0);
    step_to(43); chk("R4 at", int'(reg_rdata[2:0]), 3'b110);

    // R5 postponed done with acknowledge
    ack_en = 1; ack_in = 1;
    start_frame(1, 8'h12);
    step_to(43 + IFS - 1); chk("R5 postponed", int'(reg_rdata[2]), 0);
    step_to(43 + IFS); chk("R5 done", int'(reg_rdata[5:0]), 6'b000110);

    // R5 early acknowledge ignored
    ack_in = 0;
    start_frame(1, 8'h13);
    step_to(14); ack_in = 1; step_to(15); ack_in = 0;
    wait_end("R5 end");
    chk("R5 noack", int'(reg_rdata[5:0]), 6'b100010);

    // R6 broadcast without ack
    bcast = 1;
    start_frame(1, 8'h14); wait_end("R6 end");
    chk("R6 bcast", int'(reg_rdata[5:0]), 6'b000110);
    bcast = 0; ack_en = 0;

    // R7 collisions in data, checksum, closing flag
    start_frame(1, 8'h15); pulse_coll(14); wait_end("R7 end");
    chk("R7 data", int'(reg_rdata[5:0]), 6'b001010);
    start_frame(1, 8'h16); pulse_coll(25); wait_end("R7 end");
    chk("R7 crc", int'(reg_rdata[5:0]), 6'b001010);
    start_frame(1, 8'h17); pulse_coll(38); wait_end("R7 end");
    chk("R7 eflag", int'(reg_rdata[5:0]), 6'b000010);

    // R8 collision limit
    start_frame(1, 8'h18);
    for (int i = 0; i < 8; i++) pulse_coll(lat + 1);
    wait_end("R8 end");
    chk("R8 eight", int'(reg_rdata[5:0]), 6'b000110);
    start_frame(1, 8'h19);
    for (int i = 0; i < 9; i++) pulse_coll(lat + 1);
    wait_end("R8 end");
    chk("R8 nine", int'(reg_rdata[5:0]), 6'b001010);

    // R9 underrun and DMA count zero
    dma_mode = 1;
    start_frame(2, 8'h20); wait_end("R9 end");
    chk("R9 under", int'(reg_rdata[5:0]), 6'b010010);
    dma_zero = 1;
    start_frame(2, 8'h22); wait_end("R9 end");
    chk("R9 zero", int'(reg_rdata[5:0]), 6'b000110);
    dma_mode = 0; dma_zero = 0;

    // R10 abort
    start_frame(2, 8'h30);
    step_to(20);
    begin
      int l0;
      reg_wr = 1; reg_wdata = 8'h00; step_to(21); reg_wr = 0;
      chk("R10 high", int'(tx_hold_hi), 1);
      l0 = loads;
      repeat (80) @(negedge clk);
      chk("R10 no flag", int'(reg_rdata[5:0]), 6'b000010);
      chk("R10 no load", loads, l0);
    end

    // random frames: R4 R5 R6 R8 R9 R11
    tick_rand = 1;
    for (int it = 0; it < 40; it++) begin
      int n, k; logic ae, bc, ag, dm, dz;
      n = 1 + int'($urandom % 3);
      k = ($urandom % 3 == 0) ? 7 + int'($urandom % 4) : int'($urandom % 3);
      ae = 1'($urandom); bc = 1'($urandom); ag = 1'($urandom);
      dm = 1'($urandom); dz = 1'($urandom);
      ack_en = ae; bcast = bc; dma_mode = dm; dma_zero = dz; ack_in = ag;
      start_frame(n, 8'(it * 4));
      for (int i = 0; i < k; i++) begin
        @(negedge clk); coll_in = 1; @(negedge clk); coll_in = 0;
      end
      wait_end("R11 end");
      chk("R11 outcome", int'(reg_rdata[5:0]), int'(outcome(n, k, ae, bc, ag, dm, dz)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule